// File: doc/BRIEF.md
# UART Baud Tick Generator

This block turns the module clock into the timing strobes a UART transmitter and receiver need. The clock can first pass through an optional divide-by-eight prescaler. A clock divisor counter then produces a sample strobe once every `clk_div` prescaled clocks. An oversampling counter groups `ovs_div + 1` sample strobes into one bit period. It raises a bit strobe at the end of each bit and a mid-bit strobe partway through, which the receiver uses to pick the centre of a bit.

Software programs the divisors while the serial paths are stopped, then pulses `path_rst` to restart every counter from a known phase. A divisor written while the generator is running never cuts the current count short. The new value is taken at the next reload of the counter it belongs to. All outputs are single-cycle strobes with no handshake, because they carry timing, not data. A consumer that is not ready simply ignores a strobe.

Top module: `baud_tick_gen`

## Requirements
- R1: While `rst_n` is low all three strobes are 0. The first cycle after reset is released behaves like a `path_rst` cycle, so the first sample strobe comes `P-1` cycles after the first clock edge that sees `rst_n` high.
- R2: With `sel_div8` = 0 and `clk_div` = N ≥ 1, `samp_tick` pulses once every N clock cycles. Here P = N.
- R3: With `sel_div8` = 1, every sample period is eight times longer (P = 8·N). Two sample strobes are never adjacent.
- R4: `bit_tick` pulses together with every (B+1)-th `samp_tick` of a bit period, and only together with a sample strobe. B is the effective oversampling value.
- R5: `mid_tick` pulses together with the floor((B+1)/2)-th `samp_tick` of each bit period. It is never high in the same cycle as `bit_tick`.
- R6: While the loaded clock divisor is 0, no strobe of any kind is produced.
- R7: An `ovs_div` value below 4 is treated as 4, so a bit always spans at least five sample strobes.
- R8: A change to `clk_div` takes effect at the next sample-counter reload, and a change to `ovs_div` takes effect at the next bit-counter reload. The period in progress keeps its old length.
- R9: In a cycle where `path_rst` is high, no strobe is emitted. The clock edge that samples it clears the prescaler, sample counter and bit counter and loads both divisors. The first sample strobe then appears in cycle c0+P-1, where c0 is that edge.
- R10: When P ≥ 2 each strobe is exactly one cycle wide, and `bit_tick` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| path_rst | input | 1 | Synchronous restart pulse for all counters |
| sel_div8 | input | 1 | 1 selects the clock divided by eight as the divisor input |
| clk_div | input | CD_W (16) | Clock divisor N; 0 holds the generator idle |
| ovs_div | input | OVS_W (8) | Oversampling value B; a bit lasts B+1 samples |
| samp_tick | output | 1 | Sample strobe |
| bit_tick | output | 1 | End-of-bit strobe |
| mid_tick | output | 1 | Mid-bit strobe |

## Verification
The assertions assume that `rst_n` is released away from a clock edge and that the prescaler setting stays put around a sample strobe whenever the spacing of strobes is judged. They also rely on the bit length never falling below five samples, which the clamp of R7 guarantees whatever `ovs_div` holds. The stimulus changes every input only on falling clock edges. It changes `sel_div8` only together with a `path_rst` pulse, and it changes divisors in mid-run only in the test aimed at R8, so that every other window has one fixed configuration to model.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
  // Smallest oversampling value the bit counter accepts.
  localparam int unsigned OVS_FLOOR = 4;
  // Ratio of the optional prescaler.
  localparam int unsigned PRE_RATIO = 8;
endpackage

// File: rtl/baud_prescale.sv
module baud_prescale #(
  parameter int unsigned RATIO = baud_gen_pkg::PRE_RATIO
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic sel,
  output logic en_o
);
  localparam int unsigned PW = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [PW-1:0] LAST = PW'(RATIO - 1);

  logic [PW-1:0] pcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
    end else if (restart) begin
      pcnt <= '0;
    end else if (pcnt == LAST) begin
      pcnt <= '0;
    end else begin
      pcnt <= pcnt + PW'(1);
    end
  end

  // Divided path gives one enable per RATIO clocks; direct path enables every clock.
  assign en_o = sel ? (pcnt == LAST) : 1'b1;
endmodule

// File: rtl/baud_sample_div.sv
module baud_sample_div #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         en,
  input  logic [W-1:0] div,
  output logic         tick_o
);
  logic [W-1:0] lim;
  logic [W-1:0] scnt;
  logic         live;
  logic         hit;

  assign live = (lim != '0);
  assign hit  = en && live && (scnt == lim - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim  <= '0;
      scnt <= '0;
    end else if (restart) begin
      lim  <= div;
      scnt <= '0;
    end else if (en) begin
      if (!live) begin
        // Idle on a zero divisor; pick up a new value on each enable.
        lim  <= div;
        scnt <= '0;
      end else if (hit) begin
        lim  <= div;
        scnt <= '0;
      end else begin
        scnt <= scnt + W'(1);
      end
    end
  end

  assign tick_o = hit;
endmodule

// File: rtl/baud_bit_div.sv
module baud_bit_div #(
  parameter int unsigned W     = 8,
  parameter int unsigned FLOOR = baud_gen_pkg::OVS_FLOOR
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         samp,
  input  logic [W-1:0] ovs,
  output logic         bit_o,
  output logic         mid_o
);
  localparam logic [W-1:0] MINV = W'(FLOOR);

  logic [W-1:0] ovs_eff;
  logic [W-1:0] olim;
  logic [W-1:0] bcnt;
  logic [W:0]   half_m1;

  assign ovs_eff = (ovs < MINV) ? MINV : ovs;
  assign half_m1 = (({1'b0, olim} + (W+1)'(1)) >> 1) - (W+1)'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      olim <= MINV;
      bcnt <= '0;
    end else if (restart) begin
      olim <= ovs_eff;
      bcnt <= '0;
    end else if (samp) begin
      if (bcnt == olim) begin
        olim <= ovs_eff;
        bcnt <= '0;
      end else begin
        bcnt <= bcnt + W'(1);
      end
    end
  end

  assign bit_o = samp && (bcnt == olim);
  assign mid_o = samp && ({1'b0, bcnt} == half_m1);
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int unsigned CD_W  = 16,
  parameter int unsigned OVS_W = 8,
  parameter int unsigned PRE   = baud_gen_pkg::PRE_RATIO
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             path_rst,
  input  logic             sel_div8,
  input  logic [CD_W-1:0]  clk_div,
  input  logic [OVS_W-1:0] ovs_div,
  output logic             samp_tick,
  output logic             bit_tick,
  output logic             mid_tick
);
  logic start_q;
  logic restart;
  logic pre_en;
  logic samp_raw;
  logic bit_raw;
  logic mid_raw;

  // First cycle out of reset acts as a restart so divisors are loaded.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= 1'b1;
    else        start_q <= 1'b0;
  end

  assign restart = path_rst | start_q;

  baud_prescale #(.RATIO(PRE)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .sel     (sel_div8),
    .en_o    (pre_en)
  );

  baud_sample_div #(.W(CD_W)) u_samp (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .en      (pre_en),
    .div     (clk_div),
    .tick_o  (samp_raw)
  );

  baud_bit_div #(.W(OVS_W)) u_bit (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .samp    (samp_raw),
    .ovs     (ovs_div),
    .bit_o   (bit_raw),
    .mid_o   (mid_raw)
  );

  assign samp_tick = samp_raw & ~restart;
  assign bit_tick  = bit_raw  & ~restart;
  assign mid_tick  = mid_raw  & ~restart;
endmodule

// File: rtl/baud_tick_chk.sv
module baud_tick_chk (
  input logic clk,
  input logic rst_n,
  input logic path_rst,
  input logic sel_div8,
  input logic samp_tick,
  input logic bit_tick,
  input logic mid_tick
);
  assert_bit_on_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> samp_tick);

  assert_mid_on_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mid_tick |-> (samp_tick && !bit_tick));

  assert_quiet_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    path_rst |-> (!samp_tick && !bit_tick && !mid_tick));

  assert_prescale_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_tick && sel_div8) |=> (!sel_div8 || !samp_tick));

  assert_bit_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick);
endmodule

bind baud_tick_gen baud_tick_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .path_rst  (path_rst),
  .sel_div8  (sel_div8),
  .samp_tick (samp_tick),
  .bit_tick  (bit_tick),
  .mid_tick  (mid_tick)
);

// File: tb/tb_baud_tick_gen.sv
module tb_baud_tick_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        path_rst = 1'b0;
  logic        sel_div8 = 1'b0;
  logic [15:0] clk_div = 16'd3;
  logic [7:0]  ovs_div = 8'd4;
  logic        samp_tick, bit_tick, mid_tick;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit armed = 1'b0;
  string cur_req = "R1";
  int exp_q[3][$];
  string kname[3] = '{"samp_tick", "bit_tick", "mid_tick"};

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  baud_tick_gen dut (
    .clk(clk), .rst_n(rst_n), .path_rst(path_rst), .sel_div8(sel_div8),
    .clk_div(clk_div), .ovs_div(ovs_div),
    .samp_tick(samp_tick), .bit_tick(bit_tick), .mid_tick(mid_tick)
  );

  // Monitor: compare each strobe against the head of its expectation queue.
  task automatic mon_one(int k, logic obs);
    if (obs) begin
      checks++;
      if (exp_q[k].size() == 0 || exp_q[k][0] != cyc) begin
        errors++;
        $display("FAIL %s: %s high at cycle %0d, expected next at %0d", cur_req, kname[k], cyc,
                 (exp_q[k].size() == 0) ? -1 : exp_q[k][0]);
      end else begin
        void'(exp_q[k].pop_front());
      end
    end else if (exp_q[k].size() > 0 && exp_q[k][0] == cyc) begin
      checks++;
      errors++;
      $display("FAIL %s: %s low at cycle %0d, expected 1 got 0", cur_req, kname[k], cyc);
      void'(exp_q[k].pop_front());
    end
  endtask

  always begin
    @(negedge clk);
    #1;
    if (armed) begin
      mon_one(0, samp_tick);
      mon_one(1, bit_tick);
      mon_one(2, mid_tick);
    end
  end

  function automatic int eff_b(int b);
    return (b < 4) ? 4 : b;  // R7 clamp
  endfunction

  // Driver model: sample times, then bit/mid positions counted over them.
  task automatic expect_seq(int c0, int p1, int p2, int b1, int b2, int span);
    int t = c0 + p1 - 1;
    int n = 0;
    int lim = eff_b(b1);
    while (t < c0 + span) begin
      exp_q[0].push_back(t);
      n++;
      if (n == (lim + 1) / 2) exp_q[2].push_back(t);
      if (n == lim + 1) begin
        exp_q[1].push_back(t);
        n = 0;
        lim = eff_b(b2);
      end
      t += p2;
    end
  endtask

  task automatic end_window();
    armed = 1'b0;
    for (int k = 0; k < 3; k++) begin
      checks++;
      if (exp_q[k].size() != 0) begin
        errors++;
        $display("FAIL %s: %s pending %0d strobes, expected 0", cur_req, kname[k], exp_q[k].size());
      end
      exp_q[k].delete();
    end
  endtask

  task automatic run_cfg(string req, bit sel, int cd, int b, int span,
                         int chg_after, int cd2, int b2);
    int c0, pre;
    cur_req = req;
    @(negedge clk);
    sel_div8 = sel;
    clk_div  = 16'(cd);
    ovs_div  = 8'(b);
    path_rst = 1'b1;
    #1;
    checks++;  // R9: restart cycle is quiet
    if (samp_tick || bit_tick || mid_tick) begin
      errors++;
      $display("FAIL R9: strobes %b%b%b during path_rst, expected 000", samp_tick, bit_tick, mid_tick);
    end
    @(negedge clk);
    path_rst = 1'b0;
    c0 = cyc;
    pre = sel ? 8 : 1;
    if (cd != 0) begin
      if (chg_after >= 0) expect_seq(c0, pre * cd, pre * cd2, b, b2, span);
      else                expect_seq(c0, pre * cd, pre * cd, b, b, span);
    end
    armed = 1'b1;
    if (chg_after >= 0) begin
      repeat (chg_after) @(negedge clk);
      clk_div = 16'(cd2);
      ovs_div = 8'(b2);
    end
    while (cyc < c0 + span) @(negedge clk);
    end_window();
  endtask

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    #1;
    checks++;  // R1: quiet in reset
    if (samp_tick || bit_tick || mid_tick) begin
      errors++;
      $display("FAIL R1: strobes %b%b%b in reset, expected 000", samp_tick, bit_tick, mid_tick);
    end
    @(negedge clk);
    rst_n = 1'b1;
    c0 = cyc + 1;
    cur_req = "R1";
    expect_seq(c0, 3, 3, 4, 4, 60);
    armed = 1'b1;
    while (cyc < c0 + 60) @(negedge clk);
    end_window();

    run_cfg("R2", 1'b0, 1, 4, 40, -1, 0, 0);
    run_cfg("R2", 1'b0, 7, 5, 150, -1, 0, 0);
    run_cfg("R3", 1'b1, 2, 5, 400, -1, 0, 0);
    run_cfg("R4", 1'b0, 5, 9, 260, -1, 0, 0);
    run_cfg("R5", 1'b0, 3, 6, 120, -1, 0, 0);
    run_cfg("R6", 1'b0, 0, 4, 100, -1, 0, 0);
    run_cfg("R7", 1'b0, 2, 1, 80, -1, 0, 0);
    run_cfg("R8", 1'b0, 10, 4, 160, 3, 4, 6);
    run_cfg("R9", 1'b1, 1, 4, 120, -1, 0, 0);
    run_cfg("R10", 1'b0, 1, 255, 600, -1, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run still going, expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule